// File: doc/BRIEF.md
# I2C Misplaced-Condition Error Detector

This block sits beside an I2C serial engine and watches the bus lines together with the engine's report of where it stands inside a frame. When a START or a STOP shows up while a byte or an acknowledge bit is still in flight, the frame has been broken. If the node is taking part in the transfer, the block starts a fixed recovery. The node counts as taking part when it drives the bus as master or has been addressed as a slave. In any other state the broken frame belongs to other devices, and the block ignores it.

The recovery happens in one registered cycle:
- A mode-reset pulse drops the engine to not-addressed slave. The same pulse sends the engine's bit counter and frame phase back to idle.
- Release strobes tell the pad logic to let go of both SCL and SDA.
- A sticky interrupt flag is raised.
- The status byte is loaded with 00H.

At all other times the engine writes the status byte itself. Software clears the interrupt flag.

Top module: `i2c_berr_guard`

## Requirements
- R1: A START is SDA going from 1 to 0 while SCL is 1. A STOP is SDA going from 0 to 1 while SCL is 1. Both are judged on the synchronised line samples. An SDA change while SCL is 0 is neither, and never raises an error.
- R2: A START or STOP seen while `phase_i` is 1 (address bits), 2 (data bits) or 3 (acknowledge bit) raises a bus error, provided `involved_i` is 1.
- R3: While `involved_i` is 0, a misplaced START or STOP has no effect on any output.
- R4: A START or STOP while `phase_i` is 0 (idle or between frames) is legal and has no effect on any output.
- R5: A bus error drives `mode_rst_o` high for exactly one cycle. It rises on the third rising clock edge after the SDA change at the pins, counting the default two synchroniser stages. The engine uses this pulse to return to not-addressed slave and to reset its bit counter and phase to idle.
- R6: `rel_scl_o` and `rel_sda_o` pulse high in the same cycle as `mode_rst_o`.
- R7: A bus error sets `irq_o`. The flag stays set until `irq_clr_i` is pulsed with no error in that cycle.
- R8: A bus error loads `status_o` with 00H. Otherwise `stat_wr_i` loads `status_o` from `stat_d_i`. A new error while `irq_o` is already set leaves the status at 00H.
- R9: When a bus error falls in the same cycle as `irq_clr_i` or `stat_wr_i`, the error wins: `irq_o` is 1 and `status_o` is 00H.
- R10: After reset, `mode_rst_o`, `rel_scl_o`, `rel_sda_o` and `irq_o` are 0, and `status_o` is F8H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL level at the pad |
| sda_i | input | 1 | SDA level at the pad |
| phase_i | input | 2 | Engine frame phase: 0 idle, 1 address, 2 data, 3 acknowledge |
| involved_i | input | 1 | Node is master or addressed slave |
| irq_clr_i | input | 1 | Software clear of the interrupt flag |
| stat_wr_i | input | 1 | Engine status write strobe |
| stat_d_i | input | 8 | Engine status value |
| mode_rst_o | output | 1 | One-cycle pulse: return to not-addressed slave, reset bit counter and phase |
| rel_scl_o | output | 1 | Release pulse for SCL |
| rel_sda_o | output | 1 | Release pulse for SDA |
| irq_o | output | 1 | Sticky interrupt flag |
| status_o | output | 8 | Status byte |

## Verification
Two things can land on the status and flag registers in the same cycle. One is a detected bus error. The other is a software flag clear together with an engine status write. The bench raises both strobes in the one cycle where the error's registered response lands. It then checks that the flag reads 1 and the status reads 00H, not the written value. A second pass repeats the clear and write with no error, to confirm that each strobe works on its own.

// File: rtl/i2c_berr_pkg.sv
package i2c_berr_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_ACK  = 2'd3
  } frame_ph_e;

  localparam int LINE_CNT = 2;
  localparam int LINE_SCL = 0;
  localparam int LINE_SDA = 1;
endpackage

// File: rtl/berr_line_sync.sv
module berr_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk) begin
    if (rst) pipe_q <= '1;
    else     pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/berr_cond_detect.sv
module berr_cond_detect (
  input  logic clk,
  input  logic rst,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic start_o,
  output logic stop_o
);
  logic scl_prev_q, sda_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_prev_q <= scl_s_i;
      sda_prev_q <= sda_s_i;
    end
  end

  // Both samples of SCL high around an SDA edge
  assign start_o = scl_s_i && scl_prev_q && sda_prev_q && !sda_s_i;
  assign stop_o  = scl_s_i && scl_prev_q && !sda_prev_q && sda_s_i;

  p_cond_exclusive_r1: assert property (@(posedge clk) disable iff (rst)
    !(start_o && stop_o));
  p_cond_needs_scl_r1: assert property (@(posedge clk) disable iff (rst)
    (start_o || stop_o) |-> scl_s_i && $past(scl_s_i));
endmodule

// File: rtl/berr_responder.sv
module berr_responder
  import i2c_berr_pkg::*;
#(
  parameter int          STAT_W   = 8,
  parameter logic [STAT_W-1:0] IDLE_STAT = 8'hF8,
  parameter logic [STAT_W-1:0] ERR_STAT  = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cond_i,
  input  frame_ph_e         phase_i,
  input  logic              involved_i,
  input  logic              irq_clr_i,
  input  logic              stat_wr_i,
  input  logic [STAT_W-1:0] stat_d_i,
  output logic              mode_rst_o,
  output logic              rel_scl_o,
  output logic              rel_sda_o,
  output logic              irq_o,
  output logic [STAT_W-1:0] status_o
);
  logic hit;
  assign hit = cond_i && involved_i && (phase_i != PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_rst_o <= 1'b0;
      rel_scl_o  <= 1'b0;
      rel_sda_o  <= 1'b0;
      irq_o      <= 1'b0;
      status_o   <= IDLE_STAT;
    end else begin
      mode_rst_o <= hit;
      rel_scl_o  <= hit;
      rel_sda_o  <= hit;
      if (hit)            irq_o <= 1'b1;
      else if (irq_clr_i) irq_o <= 1'b0;
      if (hit)            status_o <= ERR_STAT;
      else if (stat_wr_i) status_o <= stat_d_i;
    end
  end

  p_err_cause_r2: assert property (@(posedge clk) disable iff (rst)
    mode_rst_o |-> $past(cond_i) && $past(involved_i) && ($past(phase_i) != PH_IDLE));
  p_release_both_r6: assert property (@(posedge clk) disable iff (rst)
    mode_rst_o |-> rel_scl_o && rel_sda_o);
  p_err_flag_r7: assert property (@(posedge clk) disable iff (rst)
    mode_rst_o |-> irq_o);
  p_irq_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    $past(irq_o) && !$past(irq_clr_i) |-> irq_o);
  p_err_status_r8: assert property (@(posedge clk) disable iff (rst)
    mode_rst_o |-> status_o == ERR_STAT);
  p_status_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !mode_rst_o && !$past(stat_wr_i) |-> $stable(status_o));
endmodule

// File: rtl/i2c_berr_guard.sv
module i2c_berr_guard
  import i2c_berr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STAT_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        phase_i,
  input  logic              involved_i,
  input  logic              irq_clr_i,
  input  logic              stat_wr_i,
  input  logic [STAT_W-1:0] stat_d_i,
  output logic              mode_rst_o,
  output logic              rel_scl_o,
  output logic              rel_sda_o,
  output logic              irq_o,
  output logic [STAT_W-1:0] status_o
);
  logic [LINE_CNT-1:0] raw_lines, synced;
  logic start_w, stop_w;

  assign raw_lines[LINE_SCL] = scl_i;
  assign raw_lines[LINE_SDA] = sda_i;

  for (genvar g = 0; g < LINE_CNT; g++) begin : g_sync
    berr_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst(rst), .d_i(raw_lines[g]), .q_o(synced[g])
    );
  end

  berr_cond_detect i_detect (
    .clk(clk), .rst(rst),
    .scl_s_i(synced[LINE_SCL]), .sda_s_i(synced[LINE_SDA]),
    .start_o(start_w), .stop_o(stop_w)
  );

  berr_responder #(.STAT_W(STAT_W)) i_resp (
    .clk(clk), .rst(rst),
    .cond_i(start_w || stop_w),
    .phase_i(frame_ph_e'(phase_i)),
    .involved_i(involved_i),
    .irq_clr_i(irq_clr_i),
    .stat_wr_i(stat_wr_i),
    .stat_d_i(stat_d_i),
    .mode_rst_o(mode_rst_o),
    .rel_scl_o(rel_scl_o),
    .rel_sda_o(rel_sda_o),
    .irq_o(irq_o),
    .status_o(status_o)
  );

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    $past(phase_i) == 2'd0 |-> !mode_rst_o);
  p_uninvolved_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(involved_i) |-> !mode_rst_o);
endmodule

// File: tb/test_i2c_berr_guard.sv
module test_i2c_berr_guard;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic scl = 1'b1, sda = 1'b1, involved = 1'b0, irq_clr = 1'b0, stat_wr = 1'b0;
  logic [1:0] phase = 2'd0;
  logic [7:0] stat_d = 8'h00, status;
  logic mode_rst, rel_scl, rel_sda, irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_berr_guard i_i2c_berr_guard (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda), .phase_i(phase),
    .involved_i(involved), .irq_clr_i(irq_clr), .stat_wr_i(stat_wr),
    .stat_d_i(stat_d), .mode_rst_o(mode_rst), .rel_scl_o(rel_scl),
    .rel_sda_o(rel_sda), .irq_o(irq), .status_o(status)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // kind 0: start, 1: stop, 2: SDA toggle with SCL low
  task automatic run_case(input int kind, input logic [1:0] ph, input logic inv,
                          input logic collide);
    logic err;
    err = inv && (ph != 2'd0) && (kind != 2);
    // quiet setup, nothing involved
    involved = 1'b0; phase = 2'd0; scl = 1'b0; cycles(1);
    sda = (kind == 1) ? 1'b0 : 1'b1; cycles(1);
    scl = (kind == 2) ? 1'b0 : 1'b1; cycles(5);
    irq_clr = 1'b1; stat_wr = 1'b1; stat_d = 8'h55; cycles(1);
    irq_clr = 1'b0; stat_wr = 1'b0;
    phase = ph; involved = inv; cycles(1);
    sda = ~sda;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    if (collide) begin irq_clr = 1'b1; stat_wr = 1'b1; stat_d = 8'h77; end
    @(posedge clk); @(negedge clk);
    irq_clr = 1'b0; stat_wr = 1'b0;
    if (collide) begin
      chk("R9 irq", {7'd0, irq}, {7'd0, err});
      chk("R9 status", status, err ? 8'h00 : 8'h77);
    end else begin
      chk(err ? "R2 mode_rst" : (!inv ? "R3 mode_rst" : (ph == 2'd0 ? "R4 mode_rst" : "R1 mode_rst")),
          {7'd0, mode_rst}, {7'd0, err});
      chk("R6 release", {6'd0, rel_scl, rel_sda}, {6'd0, err, err});
      chk("R7 irq", {7'd0, irq}, {7'd0, err});
      chk("R8 status", status, err ? 8'h00 : 8'h55);
    end
    cycles(1);
    chk("R5 pulse end", {7'd0, mode_rst}, 8'h00);
    cycles(3);
    chk("R7 irq held", {7'd0, irq}, {7'd0, err});
  endtask

  initial begin
    cycles(3);
    chk("R10 outputs", {4'd0, mode_rst, rel_scl, rel_sda, irq}, 8'h00);
    chk("R10 status", status, 8'hF8);
    rst = 1'b0;
    cycles(2);
    for (int k = 0; k < 3; k++)
      for (int p = 0; p < 4; p++)
        for (int v = 0; v < 2; v++)
          run_case(k, 2'(p), 1'(v), 1'b0);
    // error coinciding with clear and status write
    run_case(0, 2'd2, 1'b1, 1'b1);
    run_case(1, 2'd3, 1'b1, 1'b1);
    run_case(0, 2'd1, 1'b0, 1'b1);
    // second error while flag already set keeps 00H
    involved = 1'b0; phase = 2'd0; scl = 1'b0; cycles(1);
    sda = 1'b1; cycles(1); scl = 1'b1; cycles(4);
    phase = 2'd1; involved = 1'b1; cycles(1);
    sda = 1'b0; cycles(4);
    stat_wr = 1'b1; stat_d = 8'h33; cycles(1); stat_wr = 1'b0;
    chk("R8 engine write", status, 8'h33);
    sda = 1'b1; cycles(4);
    chk("R8 repeat error", status, 8'h00);
    chk("R7 still set", {7'd0, irq}, 8'h01);
    involved = 1'b0;
    irq_clr = 1'b1; cycles(1); irq_clr = 1'b0;
    chk("R7 cleared", {7'd0, irq}, 8'h00);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule